// File: doc/BRIEF.md
# Interval and Free-Run Timer Channel

This block is one timer channel that sits behind a simple register bus. Software picks one of two modes. In the reloading interval mode the channel raises an event every N ticks. In the free-running mode an up-counter gives a monotonic time base and raises a single event when it matches a compare value. Counting advances only on cycles where the timer tick enable is high, so a slower time base can be derived from the system clock.

Software stores a compare value and a mode bit, then starts the channel by writing a start trigger. It stops the channel through a separate stop trigger and can confirm the stop by polling a read-only running flag. The compare value and the mode are copied into a working set at each start. Writes made while the channel runs are therefore kept in the registers but change nothing until the next start. The interrupt output is a one-cycle pulse for each event.

Top module: `pulse_timer_ch`

## Requirements
- R1: Reset, whether at power-up or in the middle of a run, clears the compare, counter and control registers. It clears the running flag (word 0x10 bit 0) to 0 and drives `irq_o` low.
- R2: The compare register at byte offset 0x00 can be read and written. Each byte lane whose `bus_be` bit is set is written, and lanes with a clear bit keep their old value. Bits at and above `TMR_W` read as 0.
- R3: A write with bit 0 set to the start trigger (0x14, lane 0) sets the running flag on the next cycle. A write with bit 0 set to the stop trigger (0x18, lane 0) clears it, so the first read after the stop write returns 0. The counter then holds its value.
- R4: Interval mode is control bit 1 = 0. Start loads the compare value C into the counter, and each tick decrements it. A tick while the counter is 0 reloads C and pulses `irq_o`, so a compare value of N-1 gives one pulse every N ticks, the first N ticks after start.
- R5: Free-run mode is control bit 1 = 1. Start clears the counter to 0, each tick increments it, and it wraps from all ones to 0. The counter is readable at offset 0x04.
- R6: In free-run mode, a tick that finds the counter equal to the compare value pulses `irq_o` in the following cycle. Counting continues afterwards.
- R7: The counter changes only on cycles with `tick_en` high while the channel runs, or on a start write.
- R8: Compare and control writes made while the channel runs are stored and read back at once. The running count keeps using the values latched at the last start.
- R9: A start write while the channel runs restarts the count from its start value, using the currently stored compare value and mode.
- R10: `irq_o` is high only while the running flag is 1. A stop write issued on the same cycle as an event suppresses that event's pulse.
- R11: The trigger registers and unmapped words read 0, and control bit 0 always reads 0. Writes to the counter, to the running flag, to unmapped words and to unaligned addresses (bus_addr[1:0] not 0) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] pick the word |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| tick_en | input | 1 | Timer tick enable; counting happens only when high |
| irq_o | output | 1 | One-cycle event pulse |

## Verification
Two situations are hard to reach from the ports. One is the free-run wrap, which needs 2^TMR_W ticks. The bench narrows the counter to 10 bits through the `TMR_W` parameter and holds `tick_en` high for more than 1024 cycles. The other is a stop write that lands on the same edge as an interval event. The bench sets the compare value to 0 so that every tick is an event, then checks that `irq_o` is low right after the stop edge.

// File: rtl/ptm_pkg.sv
// Shared constants and types for the timer channel.
// Assumes a 32-bit data bus and a 6-bit byte address, word decode on [5:2].
package ptm_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;
    localparam int LANES  = BUS_W / 8;

    // Word indices (byte offset / 4); software depends on these offsets.
    localparam logic [3:0] WRD_CMP   = 4'd0;
    localparam logic [3:0] WRD_CNT   = 4'd1;
    localparam logic [3:0] WRD_STAT  = 4'd4;
    localparam logic [3:0] WRD_START = 4'd5;
    localparam logic [3:0] WRD_STOP  = 4'd6;
    localparam logic [3:0] WRD_CTRL  = 4'd8;

    localparam int CTRL_MODE_BIT = 1;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_FREERUN  = 1'b1
    } ptm_mode_e;
endpackage

// File: rtl/ptm_regif.sv
// Register decode for the timer channel: stores compare and mode,
// produces start/stop trigger strobes and the combinational read mux.
// Assumes TMR_W <= 32; accesses with bus_addr[1:0] != 0 are ignored.
module ptm_regif
    import ptm_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [LANES-1:0]    bus_be,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [TMR_W-1:0]    cnt_val,
    input  logic                run_en,
    output logic                start_wr,
    output logic                stop_wr,
    output logic [TMR_W-1:0]    cmp_q,
    output ptm_mode_e           mode_q
);
    logic             aligned;
    logic [3:0]       word;
    logic             wr_hit;
    logic             rd_hit;
    logic [BUS_W-1:0] cmp_wide;
    logic [BUS_W-1:0] cmp_merge;
    logic [BUS_W-1:0] rd_mux;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[5:2];
    assign wr_hit  = bus_sel && bus_we && aligned;
    assign rd_hit  = bus_sel && !bus_we && aligned;

    assign start_wr = wr_hit && (word == WRD_START) && bus_be[0] && bus_wdata[0];
    assign stop_wr  = wr_hit && (word == WRD_STOP)  && bus_be[0] && bus_wdata[0];

    assign cmp_wide = BUS_W'(cmp_q);

    // Per-lane merge of write data into the stored compare value.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign cmp_merge[ln*8 +: 8] = bus_be[ln] ? bus_wdata[ln*8 +: 8]
                                                 : cmp_wide[ln*8 +: 8];
    end

    // Holds the software-visible compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_hit && (word == WRD_CMP)) begin
            cmp_q <= cmp_merge[TMR_W-1:0];
        end
    end

    // Holds the software-visible mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_INTERVAL;
        end else if (wr_hit && (word == WRD_CTRL) && bus_be[0]) begin
            mode_q <= ptm_mode_e'(bus_wdata[CTRL_MODE_BIT]);
        end
    end

    // Selects the read value for the addressed word.
    always_comb begin
        rd_mux = '0;
        case (word)
            WRD_CMP:  rd_mux = cmp_wide;
            WRD_CNT:  rd_mux = BUS_W'(cnt_val);
            WRD_STAT: rd_mux[0] = run_en;
            WRD_CTRL: rd_mux[CTRL_MODE_BIT] = mode_q;
            default:  rd_mux = '0;
        endcase
    end

    // Drives read data only during an aligned read.
    assign bus_rdata = rd_hit ? rd_mux : '0;
endmodule

// File: rtl/ptm_counter.sv
// Counter core: latches the working compare/mode at start, counts on
// tick_en in interval or free-run mode, and registers the event pulse.
// Assumes start_wr and stop_wr are never high together.
module ptm_counter
    import ptm_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start_wr,
    input  logic             stop_wr,
    input  logic [TMR_W-1:0] cmp_q,
    input  ptm_mode_e        mode_q,
    output logic             run_en,
    output ptm_mode_e        run_mode,
    output logic [TMR_W-1:0] cnt_val,
    output logic             irq_o
);
    logic [TMR_W-1:0] cmp_act;
    logic             step;
    logic             at_zero;
    logic             at_match;

    assign step     = run_en && tick_en && !start_wr && !stop_wr;
    assign at_zero  = (cnt_val == '0);
    assign at_match = (cnt_val == cmp_act);

    // Running flag and working copy of the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            run_mode <= MODE_INTERVAL;
            cmp_act  <= '0;
        end else if (start_wr) begin
            run_en   <= 1'b1;
            run_mode <= mode_q;
            cmp_act  <= cmp_q;
        end else if (stop_wr) begin
            run_en   <= 1'b0;
        end
    end

    // Counter: load on start, then step per tick by mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_val <= '0;
        end else if (start_wr) begin
            cnt_val <= (mode_q == MODE_FREERUN) ? '0 : cmp_q;
        end else if (step) begin
            if (run_mode == MODE_FREERUN) begin
                cnt_val <= cnt_val + 1'b1;
            end else if (at_zero) begin
                cnt_val <= cmp_act;
            end else begin
                cnt_val <= cnt_val - 1'b1;
            end
        end
    end

    // Event pulse, one cycle after the tick that produced it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= step && ((run_mode == MODE_FREERUN) ? at_match : at_zero);
        end
    end
endmodule

// File: rtl/pulse_timer_ch.sv
// Top of the timer channel: register decode plus counter core.
// Assumes a single clock; tick_en is synchronous to clk.
module pulse_timer_ch
    import ptm_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [5:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    output logic              irq_o
);
    logic             start_wr;
    logic             stop_wr;
    logic             run_en;
    ptm_mode_e        run_mode;
    ptm_mode_e        mode_q;
    logic [TMR_W-1:0] cmp_q;
    logic [TMR_W-1:0] cnt_val;
    logic             run_mode_fr;

    assign run_mode_fr = (run_mode == MODE_FREERUN);

    ptm_regif #(.TMR_W(TMR_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_val),
        .run_en    (run_en),
        .start_wr  (start_wr),
        .stop_wr   (stop_wr),
        .cmp_q     (cmp_q),
        .mode_q    (mode_q)
    );

    ptm_counter #(.TMR_W(TMR_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .start_wr (start_wr),
        .stop_wr  (stop_wr),
        .cmp_q    (cmp_q),
        .mode_q   (mode_q),
        .run_en   (run_en),
        .run_mode (run_mode),
        .cnt_val  (cnt_val),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/ptm_checker.sv
// Property checker for the timer channel, bound into every instance.
// Assumes it sees the trigger strobes and the counter state of the top.
module ptm_checker #(
    parameter int TMR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             start_wr,
    input logic             stop_wr,
    input logic             en,
    input logic             mode_fr,
    input logic [TMR_W-1:0] cnt,
    input logic             irq
);
    logic quiet;
    assign quiet = !start_wr && !stop_wr;

    a_r3_start_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> en);

    a_r3_stop_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !en);

    a_r10_irq_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en);

    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start_wr) |=> $stable(cnt));

    a_r5_freerun_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode_fr && tick && quiet) |=> (cnt == TMR_W'($past(cnt) + 1'b1)));

    a_r4_interval_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode_fr && tick && quiet && (cnt != '0))
            |=> (cnt == TMR_W'($past(cnt) - 1'b1)));

    a_r4_interval_event: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode_fr && tick && quiet && (cnt == '0)) |=> irq);
endmodule

bind pulse_timer_ch ptm_checker #(.TMR_W(TMR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .start_wr (start_wr),
    .stop_wr  (stop_wr),
    .en       (run_en),
    .mode_fr  (run_mode_fr),
    .cnt      (cnt_val),
    .irq      (irq_o)
);

// File: tb/pulse_timer_ch_bench.sv
module pulse_timer_ch_bench;
    localparam int TW = 10;
    localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STAT = 6'h10,
                           A_START = 6'h14, A_STOP = 6'h18, A_CTRL = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pulse_timer_ch #(.TMR_W(TW)) u_pulse_timer_ch (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_en(tick_en), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  a;
        logic [3:0]  be;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 6'h00, 4'h0, 32'h0,        32'h0,   4'd1},  // R1 compare
        '{1'b0, 6'h04, 4'h0, 32'h0,        32'h0,   4'd1},  // R1 counter
        '{1'b0, 6'h10, 4'h0, 32'h0,        32'h0,   4'd1},  // R1 flag
        '{1'b0, 6'h20, 4'h0, 32'h0,        32'h0,   4'd1},  // R1 control
        '{1'b1, 6'h00, 4'hF, 32'h0000_03A5, 32'h0,  4'd2},  // R2 word write
        '{1'b0, 6'h00, 4'h0, 32'h0,        32'h3A5, 4'd2},
        '{1'b1, 6'h00, 4'h1, 32'hFFFF_FF11, 32'h0,  4'd2},  // R2 lane 0 only
        '{1'b0, 6'h00, 4'h0, 32'h0,        32'h311, 4'd2},
        '{1'b1, 6'h00, 4'h2, 32'h0000_0100, 32'h0,  4'd2},  // R2 lane 1 only
        '{1'b0, 6'h00, 4'h0, 32'h0,        32'h111, 4'd2},
        '{1'b1, 6'h20, 4'h1, 32'h0000_0003, 32'h0,  4'd11}, // R11 ctrl bit0
        '{1'b0, 6'h20, 4'h0, 32'h0,        32'h2,   4'd11},
        '{1'b1, 6'h20, 4'h0, 32'h0,        32'h0,   4'd2},  // R2 no lane
        '{1'b0, 6'h20, 4'h0, 32'h0,        32'h2,   4'd2},
        '{1'b1, 6'h04, 4'hF, 32'h0000_0055, 32'h0,  4'd11}, // R11 counter RO
        '{1'b0, 6'h04, 4'h0, 32'h0,        32'h0,   4'd11},
        '{1'b1, 6'h10, 4'hF, 32'h0000_0001, 32'h0,  4'd11}, // R11 flag RO
        '{1'b0, 6'h10, 4'h0, 32'h0,        32'h0,   4'd11},
        '{1'b1, 6'h08, 4'hF, 32'hFFFF_FFFF, 32'h0,  4'd11}, // R11 unmapped
        '{1'b1, 6'h01, 4'hF, 32'h0000_0000, 32'h0,  4'd11}, // R11 unaligned
        '{1'b0, 6'h00, 4'h0, 32'h0,        32'h111, 4'd11},
        '{1'b0, 6'h14, 4'h0, 32'h0,        32'h0,   4'd11}, // R11 trigger reads
        '{1'b0, 6'h18, 4'h0, 32'h0,        32'h0,   4'd11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 0; bus_we = 0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] v);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        peek(a, v);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        int pulses, first_at, p1, p2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        // Table walk: register access patterns.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].a, VECS[i].be, VECS[i].d);
            end else begin
                rd(VECS[i].a, v);
                checks++;
                if (v !== VECS[i].e) begin
                    fails++;
                    $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                             VECS[i].req, i, v, VECS[i].e);
                end
            end
        end

        // R4 interval: compare 3 gives a pulse every 4 ticks.
        wr(A_CMP, 4'hF, 32'd3);
        wr(A_CTRL, 4'h1, 32'd0);
        tick_en = 1;
        wr(A_START, 4'h1, 32'd1);
        pulses = 0; first_at = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq_o) begin
                pulses++;
                if (first_at < 0) first_at = i;
            end
            if (i == 0) begin peek(A_CNT, v); check("R4 load on start", v, 32'd3); end
            if (i == 2) begin peek(A_CNT, v); check("R4 count down", v, 32'd1); end
        end
        check("R4 pulse count", pulses, 32'd9);
        check("R4 first pulse", first_at, 32'd4);
        rd(A_STAT, v);
        check("R3 flag while running", v, 32'd1);

        // R8: writes while running are stored but not applied.
        wr(A_CMP, 4'hF, 32'd7);
        wr(A_CTRL, 4'h1, 32'd2);
        p1 = -1; p2 = -1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (irq_o) begin
                if (p1 < 0) p1 = i;
                else if (p2 < 0) p2 = i;
            end
        end
        check("R8 period unchanged", p2 - p1, 32'd4);
        rd(A_CMP, v);
        check("R8 compare stored", v, 32'd7);
        rd(A_CTRL, v);
        check("R8 control stored", v, 32'd2);

        // R9 restart picks up new config: free-run, compare 7.
        wr(A_START, 4'h1, 32'd1);
        pulses = 0; first_at = -1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (irq_o) begin
                pulses++;
                if (first_at < 0) first_at = i;
            end
            if (i == 0) begin peek(A_CNT, v); check("R9 restart clears", v, 32'd0); end
            if (i == 5) begin peek(A_CNT, v); check("R5 count up", v, 32'd5); end
            if (i == 11) begin peek(A_CNT, v); check("R6 continues after match", v, 32'd11); end
        end
        check("R6 one match pulse", pulses, 32'd1);
        check("R6 match position", first_at, 32'd8);

        // R9 start while running restarts from 0.
        wr(A_START, 4'h1, 32'd1);
        #1;
        peek(A_CNT, v);
        check("R9 restart while running", v, 32'd0);

        // R7 tick gating.
        tick_en = 0;
        @(negedge clk);
        peek(A_CNT, v0);
        repeat (5) @(negedge clk);
        peek(A_CNT, v);
        check("R7 hold without tick", v, v0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            tick_en = (i % 2 == 0);
        end
        @(negedge clk);
        tick_en = 0;
        peek(A_CNT, v);
        check("R7 five ticks counted", v, v0 + 32'd5);

        // R3 stop: first read shows 0, counter holds, no pulses.
        tick_en = 1;
        wr(A_STOP, 4'h1, 32'd1);
        rd(A_STAT, v);
        check("R3 flag clear on first read", v, 32'd0);
        peek(A_CNT, v0);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (irq_o) pulses++;
        end
        peek(A_CNT, v);
        check("R3 counter holds after stop", v, v0);
        check("R10 no pulse while stopped", pulses, 32'd0);

        // R10: stop on the same edge as an interval event.
        wr(A_CMP, 4'hF, 32'd0);
        wr(A_CTRL, 4'h1, 32'd0);
        wr(A_START, 4'h1, 32'd1);
        @(negedge clk);
        @(negedge clk);
        check("R4 compare zero fires every tick", {31'b0, irq_o}, 32'd1);
        wr(A_STOP, 4'h1, 32'd1);
        check("R10 stop suppresses event", {31'b0, irq_o}, 32'd0);

        // R5 wrap of the full counter width.
        wr(A_CMP, 4'hF, 32'd5);
        wr(A_CTRL, 4'h1, 32'd2);
        wr(A_START, 4'h1, 32'd1);
        pulses = 0;
        for (int i = 0; i < 1030; i++) begin
            @(negedge clk);
            if (irq_o) pulses++;
            if (i == 1023) begin peek(A_CNT, v); check("R5 top value", v, 32'd1023); end
            if (i == 1024) begin peek(A_CNT, v); check("R5 wrap to zero", v, 32'd0); end
        end
        check("R6 single match per lap", pulses, 32'd1);

        // R1 reset in the middle of a run.
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        tick_en = 0;
        #1;
        check("R1 irq low after reset", {31'b0, irq_o}, 32'd0);
        peek(A_STAT, v);
        check("R1 flag cleared", v, 32'd0);
        peek(A_CNT, v);
        check("R1 counter cleared", v, 32'd0);
        peek(A_CMP, v);
        check("R1 compare cleared", v, 32'd0);
        peek(A_CTRL, v);
        check("R1 control cleared", v, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule